// File: doc/BRIEF.md
# Programmable Flat-Panel Raster Timing Generator

This block produces the raster timing for a flat display panel from a single pixel clock. A horizontal counter runs modulo a programmable line total, and a vertical counter steps once per line, modulo a programmable frame total. From these counters the block decodes a horizontal sync pulse, a vertical sync pulse and a data-enable window. It also reports the column and row of the current pixel inside the active area, so that an upstream pixel source knows which pixel to fetch next.

The data-enable window starts after the sync pulse plus the back porch on each axis, and covers the programmed width and height. Both ends of the window are inclusive. The vertical sync pulse is placed at the bottom of the frame: it is counted backwards from the frame total by the back porch and the sync width. Sync, data enable and the panel clock launch edge each have their own polarity bit.

Configuration is captured into shadow registers during reset and at every frame wrap. A frame therefore never mixes old and new timing. All outputs leave the block from flops.

Top module: `panel_raster_gen`

## Requirements
- R1: The column counter runs from 0 to line total − 1 and then returns to 0. The row counter advances by one at each line wrap and returns to 0 after row frame total − 1. Output position p after reset maps to column p mod line total and row (p / line total) mod frame total.
- R2: Horizontal sync is active for columns 0 through hsync width − 1 of every line.
- R3: Vertical sync is active on rows from (frame total − v back porch − vsync width) up to, but not including, row (frame total − v back porch).
- R4: Data enable is active where the column lies in [hsync width + h back porch, that start + active width − 1] and the row lies in [vsync width + v back porch, that start + active height − 1]. All bounds are inclusive.
- R5: While data enable is active, `act_col` and `act_row` give the offset from the window start on each axis. Outside the window both read 0.
- R6: When a polarity bit is 1, the active level of its output is low. This holds for hsync, vsync and data enable. `pclk_inv` carries the clock polarity bit that is in effect for the current frame.
- R7: A configuration change made in the middle of a frame has no effect on any output until the first pixel of the next frame. From that pixel on, the new values govern every output.
- R8: While reset is held, the counters sit at 0. Every sync and enable output sits at its inactive level for the configuration presented during reset, and `act_col`/`act_row` read 0. Each output lags the counter position it reflects by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_htotal | input | CW | Pixels per line, including blanking |
| cfg_vtotal | input | CW | Lines per frame, including blanking |
| cfg_hsync_w | input | SW | Horizontal sync width in pixels |
| cfg_hbp | input | SW | Horizontal back porch in pixels |
| cfg_vsync_w | input | SW | Vertical sync width in lines |
| cfg_vbp | input | SW | Vertical back porch in lines |
| cfg_width | input | CW | Active pixels per line |
| cfg_height | input | CW | Active lines per frame |
| cfg_inv_hs | input | 1 | Invert horizontal sync |
| cfg_inv_vs | input | 1 | Invert vertical sync |
| cfg_inv_de | input | 1 | Invert data enable |
| cfg_inv_clk | input | 1 | Panel clock launch-edge inversion |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_inv | output | 1 | Clock polarity in effect for the current frame |
| act_col | output | CW | Column inside the active window |
| act_row | output | CW | Row inside the active window |

## Verification
A counter that slips or wraps at the wrong total moves the hsync edges within one line. It shifts vsync and the row value by the next line, and the error grows from then on, so a per-cycle comparison against an arithmetic raster model catches it within a few cycles. A shadow register that loads at the wrong moment shows up in the first pixel after a mid-frame reconfiguration, because the sync and enable edges then move before the frame wrap. A shadow that fails to load shows up as old geometry persisting into the next frame. A decoding error on a window bound shows up as a data-enable edge or an `act_col`/`act_row` value one position away from the model.

// File: rtl/panel_raster_gen.sv
module panel_raster_gen #(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_htotal,
  input  logic [CW-1:0] cfg_vtotal,
  input  logic [SW-1:0] cfg_hsync_w,
  input  logic [SW-1:0] cfg_hbp,
  input  logic [SW-1:0] cfg_vsync_w,
  input  logic [SW-1:0] cfg_vbp,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  input  logic          cfg_inv_hs,
  input  logic          cfg_inv_vs,
  input  logic          cfg_inv_de,
  input  logic          cfg_inv_clk,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_inv,
  output logic [CW-1:0] act_col,
  output logic [CW-1:0] act_row
);

  logic [CW-1:0] hc, vc;
  logic [CW-1:0] ht_q, vt_q, wd_q, hg_q;
  logic [SW-1:0] hsw_q, hbp_q, vsw_q, vbp_q;
  logic          ih_q, iv_q, id_q, ic_q;

  logic [CW-1:0] h_beg, h_end, v_beg, v_end, vs_beg, vs_end;
  logic          line_end, frame_end, hs_on, vs_on, de_on;

  assign h_beg  = CW'(hsw_q) + CW'(hbp_q);
  assign h_end  = h_beg + wd_q - CW'(1);
  assign v_beg  = CW'(vsw_q) + CW'(vbp_q);
  assign v_end  = v_beg + hg_q - CW'(1);
  assign vs_end = vt_q - CW'(vbp_q);
  assign vs_beg = vs_end - CW'(vsw_q);

  assign line_end  = (hc == ht_q - CW'(1));
  assign frame_end = line_end && (vc == vt_q - CW'(1));

  assign hs_on = (hc < CW'(hsw_q));
  assign vs_on = (vc >= vs_beg) && (vc < vs_end);
  assign de_on = (hc >= h_beg) && (hc <= h_end) && (vc >= v_beg) && (vc <= v_end);

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      ht_q  <= cfg_htotal;
      vt_q  <= cfg_vtotal;
      wd_q  <= cfg_width;
      hg_q  <= cfg_height;
      hsw_q <= cfg_hsync_w;
      hbp_q <= cfg_hbp;
      vsw_q <= cfg_vsync_w;
      vbp_q <= cfg_vbp;
      ih_q  <= cfg_inv_hs;
      iv_q  <= cfg_inv_vs;
      id_q  <= cfg_inv_de;
      ic_q  <= cfg_inv_clk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= frame_end ? '0 : vc + CW'(1);
    end else begin
      hc <= hc + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync    <= cfg_inv_hs;
      vsync    <= cfg_inv_vs;
      de       <= cfg_inv_de;
      pclk_inv <= cfg_inv_clk;
      act_col  <= '0;
      act_row  <= '0;
    end else begin
      hsync    <= hs_on ^ ih_q;
      vsync    <= vs_on ^ iv_q;
      de       <= de_on ^ id_q;
      pclk_inv <= ic_q;
      act_col  <= de_on ? hc - h_beg : '0;
      act_row  <= de_on ? vc - v_beg : '0;
    end
  end

endmodule

// File: rtl/panel_raster_gen_chk.sv
module panel_raster_gen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] hc,
  input logic [CW-1:0] vc,
  input logic [CW-1:0] ht,
  input logic [CW-1:0] vt
);

  logic at_line_end, at_frame_end;
  assign at_line_end  = (hc == ht - CW'(1));
  assign at_frame_end = at_line_end && (vc == vt - CW'(1));

  a_r1_col_step: assert property (@(posedge clk) disable iff (rst)
    !at_line_end |=> hc == $past(hc) + CW'(1));

  a_r1_col_wrap: assert property (@(posedge clk) disable iff (rst)
    at_line_end |=> hc == '0);

  a_r1_row_step: assert property (@(posedge clk) disable iff (rst)
    (at_line_end && !at_frame_end) |=> vc == $past(vc) + CW'(1));

  a_r1_row_hold: assert property (@(posedge clk) disable iff (rst)
    !at_line_end |=> $stable(vc));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !at_frame_end |=> ($stable(ht) && $stable(vt)));

endmodule

bind panel_raster_gen panel_raster_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .hc(hc), .vc(vc), .ht(ht_q), .vt(vt_q)
);

// File: tb/tb_panel_raster_gen.sv
module tb_panel_raster_gen;
  localparam int CW = 12;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_htotal, cfg_vtotal, cfg_width, cfg_height;
  logic [SW-1:0] cfg_hsync_w, cfg_hbp, cfg_vsync_w, cfg_vbp;
  logic cfg_inv_hs, cfg_inv_vs, cfg_inv_de, cfg_inv_clk;
  logic hsync, vsync, de, pclk_inv;
  logic [CW-1:0] act_col, act_row;

  always #10 clk = ~clk;

  panel_raster_gen #(.CW(CW), .SW(SW)) dut (
    .clk(clk), .rst(rst),
    .cfg_htotal(cfg_htotal), .cfg_vtotal(cfg_vtotal),
    .cfg_hsync_w(cfg_hsync_w), .cfg_hbp(cfg_hbp),
    .cfg_vsync_w(cfg_vsync_w), .cfg_vbp(cfg_vbp),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs),
    .cfg_inv_de(cfg_inv_de), .cfg_inv_clk(cfg_inv_clk),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
    .act_col(act_col), .act_row(act_row)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit pending = 0;

  int m_hc, m_vc, m_ht, m_vt, m_hsw, m_hbp, m_vsw, m_vbp, m_w, m_h;
  int m_ih, m_iv, m_id, m_ic;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ht, input int vt, input int hsw, input int hbp,
                         input int vsw, input int vbp, input int w, input int h,
                         input bit ih, input bit iv, input bit id, input bit ic);
    cfg_htotal = CW'(ht); cfg_vtotal = CW'(vt);
    cfg_hsync_w = SW'(hsw); cfg_hbp = SW'(hbp);
    cfg_vsync_w = SW'(vsw); cfg_vbp = SW'(vbp);
    cfg_width = CW'(w); cfg_height = CW'(h);
    cfg_inv_hs = ih; cfg_inv_vs = iv; cfg_inv_de = id; cfg_inv_clk = ic;
  endtask

  task automatic load_model();
    m_ht = int'(cfg_htotal); m_vt = int'(cfg_vtotal);
    m_hsw = int'(cfg_hsync_w); m_hbp = int'(cfg_hbp);
    m_vsw = int'(cfg_vsync_w); m_vbp = int'(cfg_vbp);
    m_w = int'(cfg_width); m_h = int'(cfg_height);
    m_ih = int'(cfg_inv_hs); m_iv = int'(cfg_inv_vs);
    m_id = int'(cfg_inv_de); m_ic = int'(cfg_inv_clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      int e_hs, e_vs, e_de, e_ic, e_col, e_row, hb, vb;
      bit in_win;
      string tg;
      @(posedge clk);
      hb = m_hsw + m_hbp;
      vb = m_vsw + m_vbp;
      in_win = (m_hc >= hb) && (m_hc <= hb + m_w - 1) && (m_vc >= vb) && (m_vc <= vb + m_h - 1);
      e_hs = int'(m_hc < m_hsw) ^ m_ih;
      e_vs = int'((m_vc >= m_vt - m_vbp - m_vsw) && (m_vc < m_vt - m_vbp)) ^ m_iv;
      e_de = int'(in_win) ^ m_id;
      e_ic = m_ic;
      e_col = in_win ? m_hc - hb : 0;
      e_row = in_win ? m_vc - vb : 0;
      tg = pending ? "R7 " : "";
      if (m_hc == m_ht - 1) begin
        m_hc = 0;
        if (m_vc == m_vt - 1) begin
          m_vc = 0;
          load_model();
          pending = 0;
        end else m_vc++;
      end else m_hc++;
      @(negedge clk);
      check(int'(hsync) == e_hs, {tg, "R2 R6 hsync"}, int'(hsync), e_hs);
      check(int'(vsync) == e_vs, {tg, "R3 R6 vsync"}, int'(vsync), e_vs);
      check(int'(de) == e_de, {tg, "R4 R6 de"}, int'(de), e_de);
      check(int'(pclk_inv) == e_ic, {tg, "R6 pclk_inv"}, int'(pclk_inv), e_ic);
      check(int'(act_col) == e_col, {tg, "R1 R5 act_col"}, int'(act_col), e_col);
      check(int'(act_row) == e_row, {tg, "R1 R5 act_row"}, int'(act_row), e_row);
    end
  endtask

  initial begin
    set_cfg(20, 10, 3, 2, 2, 1, 12, 5, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hsync == 1'b0, "R8 reset hsync", int'(hsync), 0);
    check(vsync == 1'b0, "R8 reset vsync", int'(vsync), 0);
    check(de == 1'b0, "R8 reset de", int'(de), 0);
    check(act_col == '0, "R8 reset act_col", int'(act_col), 0);
    check(act_row == '0, "R8 reset act_row", int'(act_row), 0);
    check(pclk_inv == 1'b0, "R8 reset pclk_inv", int'(pclk_inv), 0);
    load_model();
    m_hc = 0; m_vc = 0;
    rst = 1'b0;
    run(2 * 20 * 10 + 37);
    set_cfg(16, 8, 2, 3, 1, 2, 8, 3, 1'b1, 1'b0, 1'b1, 1'b1);
    pending = 1;
    run(20 * 10 - 37 + 3 * 16 * 8);
    set_cfg(24, 12, 4, 1, 3, 2, 18, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    pending = 1;
    run(16 * 8 - 5 + 2 * 24 * 12);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule